// File: doc/BRIEF.md
# Truncated Fixed-Width Multiplier with Constant Bias Correction

This block multiplies two unsigned words of equal width and returns a result of that same width, representing the upper half of the double-width product. This keeps word size constant through a datapath such as a filter or transform stage. The full partial-product matrix is not built. Only the most significant columns are formed: the upper half of the matrix plus a small number of guard columns set by a parameter. A single compile-time constant stands in for the average value of the columns that are left out. A half-unit is added at the column just below the result, and the upper bits are taken. This rounds to nearest, with halves rounded up.

The block is purely combinational. It has one partial-product generator, a carry-save reduction chain, and one carry-propagate adder. The correction constant and the rounding half are combined into one extra row of the matrix, so no logic is spent on them at run time. When the guard-column count equals the word width, nothing is dropped. The block then behaves as an exact multiplier followed by round-to-nearest.

Top module: `trunc_const_mult`

## Requirements
- R1: With word width N, guard count K and T = N-K, the output equals floor((S + CU*2^T + 2^(N-1)) / 2^N). Here S is the sum of a_i*b_j*2^(i+j) over all bit pairs with i+j >= T.
- R2: A product bit a_i*b_j whose column i+j is below T has no influence on the output. Operands whose only set products fall below column T give the same output as zero operands.
- R3: The correction constant, counted in units of 2^T, is CU = floor((T+1)/4) for T >= 1 and 0 for T = 0.
- R4: When K = N, the output equals floor((A*B + 2^(N-1)) / 2^N) for every operand pair.
- R5: For every operand pair, |output - floor((A*B + 2^(N-1))/2^N)| <= floor(DMAX/2^N) + 1, where DMAX = (T-1)*2^T + 1 for T >= 1.
- R6: Summed over all operand pairs, the total of (S + CU*2^T - A*B) has a magnitude of at most 2^(2N) * 2^(T-1). This means the constant cancels the mean dropped-column value to within half a kept-column unit.
- R7: If either operand is zero, the output equals floor((CU*2^T + 2^(N-1)) / 2^N).
- R8: With both operands all ones, the output follows R1 and does not wrap past 2^N - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | DATA_W | Unsigned multiplicand |
| op_b | input | DATA_W | Unsigned multiplier |
| prod_hi | output | DATA_W | Rounded upper half of the truncated, bias-corrected product |

## Verification
All operand pairs are swept exhaustively for an 8-bit build with three guard columns, an exact 8-bit build, and a 6-bit build with four guard columns. The sweeps compare each result with a bit-level model of the kept columns, with the error bound against the true rounded product, and with the accumulated bias. Zero operands expose the constant row by itself. Operands whose products land only in dropped columns show that those columns are never formed. Hand-picked operands that put the kept sum just below a rounding boundary tell apart a correction constant of 0 from one of 1 for each build. All-ones operands probe the top of the range for wrap-around.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

   // Weight type wide enough for a double-width product of up to 30-bit words.
   typedef longint unsigned weight_t;

   localparam int unsigned MAX_DATA_W = 30;

   // Correction constant in units of the least significant kept column.
   // Mean dropped sum / 2^T = (T-1)/4 + 2^-(T+2); rounding that to an
   // integer gives floor((T+1)/4) because the small term never crosses a half.
   function automatic int unsigned corr_units(input int unsigned t);
      if (t == 0) return 0;
      return (t + 1) / 4;
   endfunction

   // Largest possible value of the dropped columns: sum (q+1)*2^q for q < T.
   function automatic weight_t dropped_max(input int unsigned t);
      if (t == 0) return '0;
      return ((weight_t'(t) - 1) << t) + 1;
   endfunction

endpackage

// File: rtl/tcm_pp_gen.sv
module tcm_pp_gen #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DROP_COL = 5
) (
   input  logic [DATA_W-1:0]                  op_a,
   input  logic [DATA_W-1:0]                  op_b,
   output logic [DATA_W-1:0][2*DATA_W-1:0]    pp_rows
);
   localparam int unsigned W2 = 2 * DATA_W;

   // Row j holds op_a scaled by op_b[j]; only columns at or above DROP_COL get an AND gate.
   for (genvar j = 0; j < DATA_W; j++) begin : g_row
      for (genvar c = 0; c < W2; c++) begin : g_col
         if ((c >= j) && (c - j < DATA_W) && (c >= DROP_COL)) begin : g_kept
            assign pp_rows[j][c] = op_a[c-j] & op_b[j];
         end else begin : g_none
            assign pp_rows[j][c] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/tcm_csa_chain.sv
module tcm_csa_chain #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned ROWS  = 9
) (
   input  logic [ROWS-1:0][WIDTH-1:0] rows_in,
   output logic [WIDTH-1:0]           sum_vec,
   output logic [WIDTH-1:0]           carry_vec
);
   if (ROWS < 3) begin : g_bad_rows
      $error("tcm_csa_chain needs at least three rows");
   end

   logic [WIDTH-1:0] st_sum   [1:ROWS-1];
   logic [WIDTH-1:0] st_carry [1:ROWS-1];

   assign st_sum[1]   = rows_in[0];
   assign st_carry[1] = rows_in[1];

   // Linear chain of 3:2 compressors: each stage folds one more row into the pair.
   for (genvar m = 2; m < ROWS; m++) begin : g_stage
      assign st_sum[m]   = st_sum[m-1] ^ st_carry[m-1] ^ rows_in[m];
      assign st_carry[m] = ((st_sum[m-1] & st_carry[m-1]) |
                            (st_sum[m-1] & rows_in[m])     |
                            (st_carry[m-1] & rows_in[m])) << 1;
   end

   assign sum_vec   = st_sum[ROWS-1];
   assign carry_vec = st_carry[ROWS-1];

   // The redundant pair must carry the same value as the plain row total (modulo width).
   logic [WIDTH-1:0] row_total;
   always_comb begin
      row_total = '0;
      for (int r = 0; r < ROWS; r++) row_total = row_total + rows_in[r];
      if (!$isunknown(rows_in) && !$isunknown(sum_vec) && !$isunknown(carry_vec)) begin
         p_csa_sum_r1: assert (row_total == WIDTH'(sum_vec + carry_vec))
            else $error("carry-save pair disagrees with row total");
      end
   end

endmodule

// File: rtl/tcm_final_add.sv
module tcm_final_add #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [2*DATA_W-1:0] addend_x,
   input  logic [2*DATA_W-1:0] addend_y,
   output logic [2*DATA_W-1:0] full_sum,
   output logic [DATA_W-1:0]   upper_half
);
   assign full_sum   = addend_x + addend_y;
   assign upper_half = full_sum[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/trunc_const_mult.sv
module trunc_const_mult #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned GUARD_COLS = 3
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] prod_hi
);
   import tcm_pkg::*;

   localparam int unsigned W2       = 2 * DATA_W;
   localparam int unsigned DROP_COL = DATA_W - GUARD_COLS;
   localparam int unsigned CU       = corr_units(DROP_COL);
   localparam weight_t     DMAX     = dropped_max(DROP_COL);
   localparam int unsigned NROWS    = DATA_W + 1;
   // Bias correction and rounding half merged into one constant row.
   localparam logic [W2-1:0] CONST_ROW = (W2'(CU) << DROP_COL) + (W2'(1) << (DATA_W - 1));

   // Elaboration-time parameter checks.
   if (DATA_W < 2 || DATA_W > MAX_DATA_W) begin : g_bad_width
      $error("DATA_W out of supported range");
   end
   if (GUARD_COLS < 1 || GUARD_COLS > DATA_W) begin : g_bad_guard
      $error("GUARD_COLS must lie in 1..DATA_W");
   end

   logic [DATA_W-1:0][W2-1:0] pp_rows;
   logic [NROWS-1:0][W2-1:0]  all_rows;
   logic [W2-1:0]             red_sum, red_carry, total;

   tcm_pp_gen #(
      .DATA_W   (DATA_W),
      .DROP_COL (DROP_COL)
   ) i_pp_gen (
      .op_a    (op_a),
      .op_b    (op_b),
      .pp_rows (pp_rows)
   );

   assign all_rows[DATA_W-1:0] = pp_rows;
   assign all_rows[DATA_W]     = CONST_ROW;

   tcm_csa_chain #(
      .WIDTH (W2),
      .ROWS  (NROWS)
   ) i_csa_chain (
      .rows_in   (all_rows),
      .sum_vec   (red_sum),
      .carry_vec (red_carry)
   );

   tcm_final_add #(
      .DATA_W (DATA_W)
   ) i_final_add (
      .addend_x   (red_sum),
      .addend_y   (red_carry),
      .full_sum   (total),
      .upper_half (prod_hi)
   );

   // ---------------- assertions ----------------
   logic [W2-1:0] prod_full;
   logic [W2-1:0] kept_part;
   assign prod_full = W2'(op_a) * W2'(op_b);
   assign kept_part = total - CONST_ROW;

   always_comb begin
      if (!$isunknown(op_a) && !$isunknown(op_b) && !$isunknown(total)) begin
         // Kept columns can only under-count the product, by at most the dropped maximum.
         p_kept_le_product_r2: assert (kept_part <= prod_full)
            else $error("kept columns exceed exact product");
         p_drop_bound_r5: assert (weight_t'(prod_full - kept_part) <= DMAX)
            else $error("dropped share larger than its maximum");
         if (op_a == '0 || op_b == '0) begin
            p_zero_operand_r7: assert (prod_hi == CONST_ROW[W2-1:DATA_W])
               else $error("zero operand does not yield constant-only result");
         end
      end
   end

   if (GUARD_COLS == DATA_W) begin : g_exact_chk
      logic [W2-1:0] rounded_ref;
      assign rounded_ref = prod_full + (W2'(1) << (DATA_W - 1));
      always_comb begin
         if (!$isunknown(op_a) && !$isunknown(op_b) && !$isunknown(prod_hi)) begin
            p_exact_mode_r4: assert (prod_hi == rounded_ref[W2-1:DATA_W])
               else $error("exact build does not round the full product");
         end
      end
   end

endmodule

// File: tb/test_trunc_const_mult.sv
module test_trunc_const_mult;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] a8 = '0, b8 = '0;
   logic [5:0] a6 = '0, b6 = '0;
   logic [7:0] y_main, y_exact;
   logic [5:0] y_small;

   trunc_const_mult #(.DATA_W(8), .GUARD_COLS(3)) i_trunc_const_mult (
      .op_a (a8), .op_b (b8), .prod_hi (y_main));
   trunc_const_mult #(.DATA_W(8), .GUARD_COLS(8)) i_trunc_const_mult_exact (
      .op_a (a8), .op_b (b8), .prod_hi (y_exact));
   trunc_const_mult #(.DATA_W(6), .GUARD_COLS(4)) i_trunc_const_mult_small (
      .op_a (a6), .op_b (b6), .prod_hi (y_small));

   // ---------- reference model built from the requirements ----------
   function automatic longint cu_of(int t);
      return (t == 0) ? 0 : (t + 1) / 4;                       // R3
   endfunction

   function automatic longint kept_sum(int n, int t, longint a, longint b);
      longint s = 0;
      for (int i = 0; i < n; i++)
         for (int j = 0; j < n; j++)
            if ((i + j >= t) && a[i] && b[j]) s += longint'(1) << (i + j);
      return s;
   endfunction

   function automatic longint model_hi(int n, int k, longint a, longint b);
      int t = n - k;
      return (kept_sum(n, t, a, b) + (cu_of(t) << t) + (longint'(1) << (n - 1))) >> n;  // R1
   endfunction

   function automatic longint round_exact(int n, longint a, longint b);
      return (a * b + (longint'(1) << (n - 1))) >> n;
   endfunction

   function automatic longint err_bound(int n, int k);
      int t = n - k;
      longint dmax = (t == 0) ? 0 : (((longint'(t) - 1) << t) + 1);
      return (t == 0) ? 0 : (dmax >> n) + 1;                   // R5
   endfunction

   task automatic chk_eq(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_le(string req, longint act, longint lim);
      checks++;
      if (act > lim) begin
         errors++;
         $display("FAIL %s: actual %0d expected at most %0d", req, act, lim);
      end
   endtask

   task automatic apply8(int a, int b);
      @(negedge clk);
      a8 = 8'(a); b8 = 8'(b);
      #2;
   endtask

   task automatic apply6(int a, int b);
      @(negedge clk);
      a6 = 6'(a); b6 = 6'(b);
      #2;
   endtask

   // ---------- scenarios ----------
   task automatic t_zero_operands;
      apply8(0, 0);
      chk_eq("R7 main zero", longint'(y_main), model_hi(8, 3, 0, 0));
      chk_eq("R7 main zero value", longint'(y_main), 0);
      chk_eq("R7 exact zero", longint'(y_exact), 0);
      apply8(0, 255);
      chk_eq("R7 main a=0", longint'(y_main), ((longint'(1) << 5) + 128) >> 8);
      apply6(63, 0);
      chk_eq("R7 small b=0", longint'(y_small), ((cu_of(2) << 2) + 32) >> 6);
   endtask

   task automatic t_dropped_columns;
      // T = 5: products of bit pairs summing below column 5 must not show.
      apply8(3, 3);
      chk_eq("R2 cols 0..2 only", longint'(y_main), 0);
      apply8(1, 16);
      chk_eq("R2 col 4 only", longint'(y_main), 0);
      apply8(7, 3);
      chk_eq("R2 cols 0..3 only", longint'(y_main), 0);
   endtask

   task automatic t_constant_value;
      // main: T=5, CU=1 -> 96 + 32 + 128 = 256 crosses; without CU it would not.
      apply8(96, 1);
      chk_eq("R3 main CU=1 boundary", longint'(y_main), 1);
      // small: T=2, CU=0 -> 28 + 0 + 32 = 60 stays below 64; CU=1 would cross.
      apply6(28, 1);
      chk_eq("R3 small CU=0 boundary", longint'(y_small), 0);
   endtask

   task automatic t_all_ones;
      apply8(255, 255);
      chk_eq("R8 main all ones", longint'(y_main), model_hi(8, 3, 255, 255));
      chk_eq("R8 exact all ones", longint'(y_exact), round_exact(8, 255, 255));
      chk_le("R8 main no wrap", longint'(y_main), 255);
      apply6(63, 63);
      chk_eq("R8 small all ones", longint'(y_small), model_hi(6, 4, 63, 63));
   endtask

   task automatic t_sweep8;
      longint bias = 0;
      longint bnd  = err_bound(8, 3);
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            longint r, d;
            apply8(a, b);
            chk_eq("R1 main sweep", longint'(y_main), model_hi(8, 3, a, b));
            chk_eq("R4 exact sweep", longint'(y_exact), round_exact(8, a, b));
            r = round_exact(8, a, b);
            d = (longint'(y_main) > r) ? longint'(y_main) - r : r - longint'(y_main);
            chk_le("R5 main error bound", d, bnd);
            bias += kept_sum(8, 5, a, b) + (cu_of(5) << 5) - longint'(a) * longint'(b);
         end
      end
      if (bias < 0) bias = -bias;
      chk_le("R6 main bias", bias, (longint'(1) << 16) * (longint'(1) << 4));
   endtask

   task automatic t_sweep6;
      longint bias = 0;
      longint bnd  = err_bound(6, 4);
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 64; b++) begin
            longint r, d;
            apply6(a, b);
            chk_eq("R1 small sweep", longint'(y_small), model_hi(6, 4, a, b));
            r = round_exact(6, a, b);
            d = (longint'(y_small) > r) ? longint'(y_small) - r : r - longint'(y_small);
            chk_le("R5 small error bound", d, bnd);
            bias += kept_sum(6, 2, a, b) + (cu_of(2) << 2) - longint'(a) * longint'(b);
         end
      end
      if (bias < 0) bias = -bias;
      chk_le("R6 small bias", bias, (longint'(1) << 12) * (longint'(1) << 1));
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      t_zero_operands();
      t_dropped_columns();
      t_constant_value();
      t_all_ones();
      t_sweep6();
      t_sweep8();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (R1): actual timeout expected completion");
      finish_run();
   end

endmodule